// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Control and Status Registers

This block receives characters from a single asynchronous serial line and hands them to software through a small register port. Each frame is a low start bit, then eight data bits least significant first, an optional ninth data bit, and a high stop bit. The bit rate comes from an 8-bit divisor and a high-speed select bit. Every bit is recovered by a three-sample majority vote taken around its centre. Completed characters go into a two-entry buffer. A receive-complete flag shows that the buffer holds data, and it drives an interrupt output when the interrupt is enabled.

Software enables the port, selects asynchronous operation, and turns on continuous receive. It then reads the status register, which gives the ninth bit, the framing flag, the overrun flag and the receive-complete flag. Next it reads the data register, and that read removes the character from the buffer. A third character that completes while both buffer entries are full is thrown away and sets overrun. From then on no further frame is accepted until software clears and sets the continuous-receive bit again.

The bit engine is a four-state machine. RX_IDLE moves to RX_START when the synchronized line is low and reception is allowed. RX_START goes back to RX_IDLE if the centre vote reads high, and otherwise moves to RX_DATA at the end of the bit. RX_DATA moves to RX_STOP after the last data bit, which is the eighth or the ninth. RX_STOP returns to RX_IDLE at the centre of the stop bit, and this is when the character is delivered. From every state the machine drops to RX_IDLE as soon as reception is no longer allowed.

Top module: `srx_top`

## Requirements
- R1: A frame is received only while CTRL bit0 (port enable) is 1, CTRL bit1 (continuous receive) is 1 and CTRL bit4 (synchronous select) is 0. Otherwise the line is ignored and STAT bit3 stays 0.
- R2: A frame with a low start bit, eight data bits least significant first and a high stop bit delivers its byte, which a read of address 3 (DATA) returns.
- R3: STAT bit3 (receive complete) is 1 exactly while the buffer holds a character. irq_out is 1 only when STAT bit3 is 1 and CTRL bit3 (interrupt enable) is 1.
- R4: When CTRL bit2 (9-bit mode) is 1, the frame carries a ninth data bit after the eighth. That bit is shown in STAT bit0 for the character at the head of the buffer.
- R5: A stop bit sampled low sets STAT bit2 (framing error) for that character only. The byte is still delivered.
- R6: The buffer holds two characters. Reading DATA removes the oldest one, so characters come out in arrival order.
- R7: A character that completes while two characters are buffered is discarded and sets STAT bit1 (overrun). While overrun is set, no frame is accepted. Overrun clears only when CTRL bit1 is written to 0.
- R8: The bit period is 64×(DIV+1) clocks when CTRL bit5 (high speed) is 0, and 16×(DIV+1) clocks when it is 1. DIV is the register at address 1.
- R9: A low pulse that has ended before the centre of the start bit is rejected. The receiver goes back to idle and delivers nothing.
- R10: After reset, CTRL (address 0), DIV (address 1) and DATA read 0, and STAT bits 3 to 1 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of DATA pops the buffer |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 DIV, 2 STAT, 3 DATA |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq_out | output | 1 | Receive interrupt |

## Verification
A table of frames covers several data patterns: all zeros, all ones, alternating bits, and 9-bit characters whose ninth bit is 1 and 0. Some frames have a good stop bit and some have a low one. Together they separate a wrong bit order, a ninth bit lost or misplaced, and a framing flag that leaks into the next character. Directed patterns then run the same byte at two matching rate settings and at one mismatched setting, which tells apart the high-speed prescale and the divisor arithmetic. A short low glitch checks start rejection, a burst of three frames with no reads checks overrun, discard and lockout, and frames sent while reception is disabled check the enable gating.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int OVS    = 16;
    localparam int SMP_W  = $clog2(OVS);
    localparam int VOTE_A = 6;
    localparam int VOTE_B = 7;
    localparam int VOTE_C = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam int CB_PORT = 0;
    localparam int CB_CONT = 1;
    localparam int CB_NINE = 2;
    localparam int CB_IRQ  = 3;
    localparam int CB_SYNC = 4;
    localparam int CB_FAST = 5;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic       ferr;
        logic       ninth;
        logic [7:0] octet;
    } rx_entry_t;

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int DIV_W    = 8,
    parameter int SLOW_PRE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    input  logic             fast,
    output logic             tick
);
    localparam int PRE_W = (SLOW_PRE > 1) ? $clog2(SLOW_PRE) : 1;
    localparam logic [PRE_W-1:0] PRE_SLOW_MAX = PRE_W'(SLOW_PRE - 1);

    logic [DIV_W-1:0] div_cnt_q;
    logic [PRE_W-1:0] pre_cnt_q;
    logic [PRE_W-1:0] pre_max;
    logic             div_wrap;

    always_comb begin
        pre_max  = fast ? '0 : PRE_SLOW_MAX;
        div_wrap = (div_cnt_q == div);
        tick     = div_wrap && (pre_cnt_q == pre_max) && !clr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_cnt_q <= '0;
            pre_cnt_q <= '0;
        end else if (div_wrap) begin
            div_cnt_q <= '0;
            if (pre_cnt_q >= pre_max) begin
                pre_cnt_q <= '0;
            end else begin
                pre_cnt_q <= pre_cnt_q + 1'b1;
            end
        end else begin
            div_cnt_q <= div_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/srx_bitfsm.sv
module srx_bitfsm
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       nine,
    input  logic       rx_s,
    input  logic       tick,
    output logic       baud_clr,
    output logic       done,
    output logic [8:0] done_word,
    output logic       done_ferr
);
    rx_state_t        state_q, state_d;
    logic [SMP_W-1:0] samp_q;
    logic [3:0]       bit_q;
    logic [8:0]       shift_q;
    logic [1:0]       votes_q;
    logic             vote;
    logic             at_mid;
    logic             at_end;
    logic [3:0]       last_bit;

    always_comb begin
        vote     = (votes_q[0] & votes_q[1]) | (votes_q[0] & rx_s) | (votes_q[1] & rx_s);
        at_mid   = tick && (samp_q == SMP_W'(VOTE_C));
        at_end   = tick && (samp_q == SMP_W'(OVS - 1));
        last_bit = nine ? 4'd8 : 4'd7;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (!rx_s) state_d = RX_START;
            end
            RX_START: begin
                if (at_mid && vote)  state_d = RX_IDLE;
                else if (at_end)     state_d = RX_DATA;
            end
            RX_DATA: begin
                if (at_end && (bit_q == last_bit)) state_d = RX_STOP;
            end
            RX_STOP: begin
                if (at_mid) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
        if (!en) state_d = RX_IDLE;
    end

    // sample counter, votes and shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            votes_q <= '0;
        end else if (state_q == RX_IDLE) begin
            samp_q <= '0;
            bit_q  <= '0;
        end else if (tick) begin
            samp_q <= (samp_q == SMP_W'(OVS - 1)) ? '0 : samp_q + 1'b1;
            if (samp_q == SMP_W'(VOTE_A)) votes_q[0] <= rx_s;
            if (samp_q == SMP_W'(VOTE_B)) votes_q[1] <= rx_s;
            if (state_q == RX_DATA && samp_q == SMP_W'(VOTE_C)) begin
                shift_q <= {vote, shift_q[8:1]};
            end
            if (state_q == RX_DATA && samp_q == SMP_W'(OVS - 1)) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        baud_clr  = (state_q == RX_IDLE);
        done      = (state_q == RX_STOP) && at_mid && en;
        done_ferr = !vote;
        done_word = nine ? shift_q : {1'b0, shift_q[8:1]};
    end

endmodule

// File: rtl/srx_buf.sv
module srx_buf
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_entry_t                  wentry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok, push_ok;

    always_comb begin
        pop_ok  = pop && (cnt_q != '0);
        push_ok = push && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);
        head    = mem_q[rd_q];
        count   = cnt_q;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[g] <= '0;
                end else if (push_ok && wr_q == PTR_W'(g)) begin
                    mem_q[g] <= wentry;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_in,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_out
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             rx_meta_q, rx_s_q;
    logic [7:0]       ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             ovr_q;
    logic             rx_enable;
    logic             tick, baud_clr;
    logic             char_done, char_ferr;
    logic [8:0]       char_word;
    logic             pop_req;
    logic             rx_flag;
    rx_entry_t        new_entry, head;
    logic [CNT_W-1:0] buf_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_meta_q <= 1'b1;
            rx_s_q    <= 1'b1;
        end else begin
            rx_meta_q <= rx_in;
            rx_s_q    <= rx_meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata;
            if (bus_addr == A_DIV)  div_q  <= DIV_W'(bus_wdata);
        end
    end

    always_comb begin
        rx_enable = ctrl_q[CB_PORT] && ctrl_q[CB_CONT] && !ctrl_q[CB_SYNC] && !ovr_q;
        pop_req   = bus_rd && (bus_addr == A_DATA);
        rx_flag   = (buf_count != '0);
        irq_out   = rx_flag && ctrl_q[CB_IRQ];
        new_entry.ferr  = char_ferr;
        new_entry.ninth = char_word[8];
        new_entry.octet = char_word[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (!ctrl_q[CB_CONT]) begin
            ovr_q <= 1'b0;
        end else if (char_done && buf_count == CNT_W'(DEPTH) && !pop_req) begin
            ovr_q <= 1'b1;
        end
    end

    srx_baud #(.DIV_W(DIV_W), .SLOW_PRE(4)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .clr  (baud_clr),
        .div  (div_q),
        .fast (ctrl_q[CB_FAST]),
        .tick (tick)
    );

    srx_bitfsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_enable),
        .nine      (ctrl_q[CB_NINE]),
        .rx_s      (rx_s_q),
        .tick      (tick),
        .baud_clr  (baud_clr),
        .done      (char_done),
        .done_word (char_word),
        .done_ferr (char_ferr)
    );

    srx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .push   (char_done),
        .wentry (new_entry),
        .pop    (pop_req),
        .head   (head),
        .count  (buf_count)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_DIV:   bus_rdata = 8'(div_q);
            A_STAT:  bus_rdata = {4'b0, rx_flag, head.ferr & rx_flag, ovr_q, head.ninth & rx_flag};
            A_DATA:  bus_rdata = rx_flag ? head.octet : 8'h00;
            default: bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/srx_checks.sv
module srx_checks #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       port_en,
    input logic                       cont_en,
    input logic                       sync_sel,
    input logic                       irq_en,
    input logic                       ovr,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       done,
    input logic                       pop,
    input logic                       flag,
    input logic                       irq
);
    p_rx_gated_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> (port_en && cont_en && !sync_sel));

    p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && flag));

    p_flag_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (pop && count == 1 && !done) |=> !flag);

    p_flag_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(done));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovr && cont_en) |=> ovr);

    p_ovr_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        ovr |-> !done);

endmodule

bind srx_top srx_checks #(.DEPTH(DEPTH)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .port_en  (ctrl_q[0]),
    .cont_en  (ctrl_q[1]),
    .sync_sel (ctrl_q[4]),
    .irq_en   (ctrl_q[3]),
    .ovr      (ovr_q),
    .count    (buf_count),
    .done     (char_done),
    .pop      (pop_req),
    .flag     (rx_flag),
    .irq      (irq_out)
);

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 64;
    localparam logic [7:0] C_BASE = 8'h23;

    // {nine, stop_high, data[8:0]}
    localparam logic [10:0] VEC [7] = '{
        {1'b0, 1'b1, 9'h0A5},
        {1'b0, 1'b1, 9'h000},
        {1'b0, 1'b1, 9'h0FF},
        {1'b1, 1'b1, 9'h13C},
        {1'b1, 1'b1, 9'h0C3},
        {1'b0, 1'b0, 9'h05A},
        {1'b1, 1'b0, 9'h181}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic [7:0] rv;

    srx_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .rx_in     (rx_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drive_bit(input logic v, input int clks);
        rx_in = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input bit nine, input bit stop_hi, input int per);
        @(negedge clk);
        drive_bit(1'b0, per);
        for (int i = 0; i < 8; i++) drive_bit(d[i], per);
        if (nine) drive_bit(d[8], per);
        if (stop_hi) drive_bit(1'b1, per);
        else drive_bit(1'b0, (per * 3) / 4);
        drive_bit(1'b1, 2 * per);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset values
        bus_read(2'd0, rv); check("R10 ctrl", rv, 0);
        bus_read(2'd1, rv); check("R10 div", rv, 0);
        bus_read(2'd3, rv); check("R10 data", rv, 0);
        bus_read(2'd2, rv); check("R10 stat", rv[3:1], 0);

        // R2 R4 R5 table walk, fast mode, divisor 3: 64 clocks per bit
        bus_write(2'd1, 8'd3);
        for (int k = 0; k < 7; k++) begin
            logic [10:0] v;
            v = VEC[k];
            bus_write(2'd0, C_BASE | (v[10] ? 8'h04 : 8'h00));
            send_frame(v[8:0], v[10], v[9], BIT_CLKS);
            bus_read(2'd2, rv);
            check("R3 flag set", rv[3], 1);
            check("R4 ninth bit", rv[0], v[10] & v[8]);
            check("R5 framing", rv[2], !v[9]);
            bus_read(2'd3, rv);
            check("R2 data byte", rv, v[7:0]);
            bus_read(2'd2, rv);
            check("R3 flag clear", rv[3], 0);
        end

        // R6 ordering, framing held per character
        bus_write(2'd0, C_BASE);
        send_frame(9'h031, 1'b0, 1'b0, BIT_CLKS);
        send_frame(9'h0C2, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd2, rv); check("R6 head ferr", rv[2], 1);
        bus_read(2'd3, rv); check("R6 first", rv, 8'h31);
        bus_read(2'd2, rv); check("R6 second ferr", rv[2], 0);
        bus_read(2'd3, rv); check("R6 second", rv, 8'hC2);

        // R1 gating
        bus_write(2'd0, C_BASE & ~8'h02);
        send_frame(9'h0AA, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd2, rv); check("R1 cont off", rv[3], 0);
        bus_write(2'd0, C_BASE | 8'h10);
        send_frame(9'h0AA, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd2, rv); check("R1 sync set", rv[3], 0);
        bus_write(2'd0, C_BASE & ~8'h01);
        send_frame(9'h0AA, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd2, rv); check("R1 port off", rv[3], 0);

        // R3 interrupt
        bus_write(2'd0, C_BASE | 8'h08);
        send_frame(9'h077, 1'b0, 1'b1, BIT_CLKS);
        @(negedge clk); #1 check("R3 irq on", irq_out, 1);
        bus_read(2'd3, rv);
        @(negedge clk); #1 check("R3 irq after pop", irq_out, 0);
        bus_write(2'd0, C_BASE);
        send_frame(9'h078, 1'b0, 1'b1, BIT_CLKS);
        @(negedge clk); #1 check("R3 irq masked", irq_out, 0);
        bus_read(2'd3, rv); check("R3 masked data", rv, 8'h78);

        // R7 overrun
        send_frame(9'h011, 1'b0, 1'b1, BIT_CLKS);
        send_frame(9'h022, 1'b0, 1'b1, BIT_CLKS);
        send_frame(9'h033, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd2, rv); check("R7 overrun set", rv[1], 1);
        bus_read(2'd3, rv); check("R7 keep first", rv, 8'h11);
        bus_read(2'd3, rv); check("R7 keep second", rv, 8'h22);
        bus_read(2'd2, rv); check("R7 third dropped", rv[3], 0);
        send_frame(9'h044, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd2, rv); check("R7 blocked", rv[3:1], 3'b001);
        bus_write(2'd0, C_BASE & ~8'h02);
        bus_write(2'd0, C_BASE);
        bus_read(2'd2, rv); check("R7 cleared", rv[1], 0);
        send_frame(9'h055, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd3, rv); check("R7 resumed", rv, 8'h55);

        // R9 start glitch
        @(negedge clk);
        drive_bit(1'b0, 12);
        drive_bit(1'b1, 3 * BIT_CLKS);
        bus_read(2'd2, rv); check("R9 glitch rejected", rv[3], 0);
        send_frame(9'h0E1, 1'b0, 1'b1, BIT_CLKS);
        bus_read(2'd3, rv); check("R9 after glitch", rv, 8'hE1);

        // R8 rate settings: 128 clocks per bit both ways
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'd1);
        send_frame(9'h096, 1'b0, 1'b1, 128);
        bus_read(2'd3, rv); check("R8 slow div1", rv, 8'h96);
        bus_write(2'd0, C_BASE);
        bus_write(2'd1, 8'd7);
        send_frame(9'h069, 1'b0, 1'b1, 128);
        bus_read(2'd3, rv); check("R8 fast div7", rv, 8'h69);
        // mismatch: 256 clocks per bit configured, 64 sent
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'd3);
        send_frame(9'h055, 1'b0, 1'b1, BIT_CLKS);
        repeat (3000) @(negedge clk);
        bus_read(2'd2, rv);
        begin
            logic [7:0] dv;
            bus_read(2'd3, dv);
            check("R8 mismatch", (rv[3] && dv == 8'h55) ? 1 : 0, 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule